// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status behaviour of a small parallel NOR flash array while it runs embedded program and erase operations. It holds a byte-wide array, split into equal sectors addressed by the upper address bits, and a per-sector protection map supplied from outside. A program or erase request starts an internal operation. While that operation runs, every read returns a status byte instead of array data.

In the status byte one bit inverts on every read, so software can detect activity by comparing two reads in a row. Another bit reports that the internal pulse budget ran out. Requests aimed only at protected storage still show a short burst of activity and then quietly return to array reads. A program that would have to turn a stored 0 into a 1 cannot succeed. It exhausts its pulse budget and the failure stays latched until a reset command is written.

All durations are clock-cycle counts set by parameters. Command-sequence unlock decoding and analog timing are not modelled.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 8'h00 and every array byte reads 8'hFF.
- R2: With `busy` low, a read (`rd_en` high) of `rd_addr` puts that array byte on `rd_data` after the next clock edge. `rd_data` holds its value between reads.
- R3: With `busy` high, a read returns a status byte, again after the next clock edge. Bit 6 of that byte is 1 on the first read after the request was accepted and inverts on each further read. Bit 5 is the failure flag. Bits 7, 4, 3, 2, 1 and 0 are 0.
- R4: A program request is `cmd_op`=2'b01. If it targets an unprotected sector and needs no 0-to-1 bit change, `busy` stays high for exactly PGM_PULSES cycles. The byte then holds the bitwise AND of its old value and `cmd_wdata`.
- R5: A program request whose address lies in a protected sector keeps `busy` high for PROT_PGM_CYC cycles and changes no data. The sector index is `cmd_addr[ADDR_W-1 -: SECT_W]` and `sect_prot[i]`=1 marks sector i as protected.
- R6: An erase request is `cmd_op`=2'b10 with `cmd_sect_sel[i]`=1 selecting sector i. If every selected sector is protected, `busy` stays high for PROT_ERS_CYC cycles and no data changes.
- R7: An erase that selects at least one unprotected sector keeps `busy` high for 2^ADDR_W cycles. It sets every byte of the selected unprotected sectors to 8'hFF and leaves all other bytes unchanged.
- R8: A program that needs a 0-to-1 change reads bit 5 as 0 for its first PULSE_LIMIT status reads (reads in cycles 1 to PULSE_LIMIT after acceptance). After that bit 5 reads 1, `busy` stays high and the target byte is unchanged.
- R9: A reset command (`cmd_op`=2'b11) written while failed clears `busy` at the next edge. A reset command written when idle changes neither data nor `busy`.
- R10: While `busy` is high, including while failed, program and erase requests are ignored.
- R11: An erase request with `cmd_sect_sel` all zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 01 program, 10 erase, 11 reset, 00 none |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_wdata | input | 8 | Program data |
| cmd_sect_sel | input | 2^SECT_W | Erase sector selection |
| sect_prot | input | 2^SECT_W | Per-sector protection map |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation active or failed |

## Verification
Reads are tried both back-to-back during an operation and one at a time while idle. This separates the status path and its alternating bit from the array path. Programs are tried in three forms: a byte going from all ones to a pattern, a pattern being narrowed to a subset of its bits, and a pattern that would need a bit raised. This tells the AND-store rule apart from a plain overwrite and shows when the latched failure occurs. Erases are tried with only protected sectors selected, with a mix of protected and unprotected sectors, and with no sectors selected. Data is placed beforehand in protected, unselected and selected sectors, so that skipped sectors and real erasure can be told apart.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'b00,
      OP_PROGRAM = 2'b01,
      OP_ERASE   = 2'b10,
      OP_RESET   = 2'b11
   } fsg_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PGM,
      ST_ERS,
      ST_PROT,
      ST_FAIL
   } fsg_state_e;

   localparam int STAT_TOGGLE_BIT = 6;
   localparam int STAT_FAIL_BIT   = 5;

   // Status byte: only the activity and failure bits are ever set
   function automatic logic [7:0] status_word(input logic tog, input logic fail);
      logic [7:0] w;
      w = 8'h00;
      w[STAT_TOGGLE_BIT] = tog;
      w[STAT_FAIL_BIT]   = fail;
      return w;
   endfunction

endpackage

// File: rtl/fsg_array.sv
module fsg_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Storage starts fully erased
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];

endmodule

// File: rtl/fsg_sequencer.sv
module fsg_sequencer
   import flash_status_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int SECT_W       = 2,
   parameter int DATA_W       = 8,
   parameter int PGM_PULSES   = 4,
   parameter int PULSE_LIMIT  = 12,
   parameter int PROT_PGM_CYC = 6,
   parameter int PROT_ERS_CYC = 40
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [1:0]               cmd_op,
   input  logic [ADDR_W-1:0]        cmd_addr,
   input  logic [DATA_W-1:0]        cmd_wdata,
   input  logic [(1<<SECT_W)-1:0]   cmd_sect_sel,
   input  logic [(1<<SECT_W)-1:0]   sect_prot,
   input  logic [DATA_W-1:0]        tgt_q,
   output logic [ADDR_W-1:0]        tgt_addr,
   output logic                     busy,
   output logic                     failed,
   output logic                     in_pgm,
   output logic                     accept,
   output logic                     we,
   output logic [ADDR_W-1:0]        waddr,
   output logic [DATA_W-1:0]        wdata
);
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int NUM_SECT = 1 << SECT_W;
   localparam int MAX_A    = (PULSE_LIMIT > PROT_PGM_CYC) ? PULSE_LIMIT : PROT_PGM_CYC;
   localparam int CNT_MAX  = (MAX_A > PROT_ERS_CYC) ? MAX_A : PROT_ERS_CYC;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   localparam logic [CNT_W-1:0]  PGM_LAST  = CNT_W'(PGM_PULSES - 1);
   localparam logic [CNT_W-1:0]  FAIL_LAST = CNT_W'(PULSE_LIMIT - 1);
   localparam logic [CNT_W-1:0]  PPGM_LAST = CNT_W'(PROT_PGM_CYC - 1);
   localparam logic [CNT_W-1:0]  PERS_LAST = CNT_W'(PROT_ERS_CYC - 1);
   localparam logic [ADDR_W-1:0] SWEEP_END = ADDR_W'(DEPTH - 1);

   fsg_state_e             state_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       lim_q;
   logic [ADDR_W-1:0]      sweep_q;
   logic [ADDR_W-1:0]      tgt_addr_q;
   logic [DATA_W-1:0]      tgt_data_q;
   logic [NUM_SECT-1:0]    ers_mask_q;

   logic [NUM_SECT-1:0]    eff_mask;
   logic [SECT_W-1:0]      cmd_sect;
   logic [SECT_W-1:0]      sweep_sect;
   logic                   pgm_blocked;
   logic                   needs_set;
   logic                   is_pgm_cmd;
   logic                   is_ers_cmd;
   logic                   is_rst_cmd;
   logic                   pgm_done;
   logic                   pgm_fail;

   // Per-sector erase eligibility: selected and not protected
   for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      assign eff_mask[s] = cmd_sect_sel[s] & ~sect_prot[s];
   end

   assign cmd_sect    = cmd_addr[ADDR_W-1 -: SECT_W];
   assign sweep_sect  = sweep_q[ADDR_W-1 -: SECT_W];
   assign pgm_blocked = sect_prot[cmd_sect];
   assign needs_set   = |(tgt_data_q & ~tgt_q);
   assign is_pgm_cmd  = cmd_valid && (cmd_op == OP_PROGRAM);
   assign is_ers_cmd  = cmd_valid && (cmd_op == OP_ERASE) && (|cmd_sect_sel);
   assign is_rst_cmd  = cmd_valid && (cmd_op == OP_RESET);
   assign pgm_done    = (state_q == ST_PGM) && !needs_set && (cnt_q == PGM_LAST);
   assign pgm_fail    = (state_q == ST_PGM) && needs_set && (cnt_q == FAIL_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         lim_q      <= '0;
         sweep_q    <= '0;
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
         ers_mask_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (is_pgm_cmd) begin
                  tgt_addr_q <= cmd_addr;
                  tgt_data_q <= cmd_wdata;
                  lim_q      <= PPGM_LAST;
                  state_q    <= pgm_blocked ? ST_PROT : ST_PGM;
               end else if (is_ers_cmd) begin
                  sweep_q    <= '0;
                  ers_mask_q <= eff_mask;
                  lim_q      <= PERS_LAST;
                  state_q    <= (|eff_mask) ? ST_ERS : ST_PROT;
               end
            end
            ST_PGM: begin
               cnt_q <= cnt_q + 1'b1;
               if (pgm_done)      state_q <= ST_IDLE;
               else if (pgm_fail) state_q <= ST_FAIL;
            end
            ST_ERS: begin
               sweep_q <= sweep_q + 1'b1;
               if (sweep_q == SWEEP_END) state_q <= ST_IDLE;
            end
            ST_PROT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == lim_q) state_q <= ST_IDLE;
            end
            ST_FAIL: begin
               if (is_rst_cmd) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign failed   = (state_q == ST_FAIL);
   assign in_pgm   = (state_q == ST_PGM);
   assign accept   = (state_q == ST_IDLE) && (is_pgm_cmd || is_ers_cmd);
   assign tgt_addr = tgt_addr_q;

   // A successful program never raises bits, so the plain data is the AND result
   assign we    = pgm_done || ((state_q == ST_ERS) && ers_mask_q[sweep_sect]);
   assign waddr = (state_q == ST_ERS) ? sweep_q : tgt_addr_q;
   assign wdata = (state_q == ST_ERS) ? '1 : tgt_data_q;

endmodule

// File: rtl/fsg_status.sv
module fsg_status
   import flash_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              busy,
   input  logic              failed,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] arr_q,
   output logic [DATA_W-1:0] rd_data
);
   logic tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q   <= 1'b0;
         rd_data <= '0;
      end else begin
         if (accept) tog_q <= 1'b0;
         if (rd_en) begin
            if (busy) begin
               tog_q   <= ~tog_q;
               rd_data <= DATA_W'(status_word(~tog_q, failed));
            end else begin
               rd_data <= arr_q;
            end
         end
      end
   end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
   parameter int ADDR_W       = 8,
   parameter int SECT_W       = 2,
   parameter int PGM_PULSES   = 4,
   parameter int PULSE_LIMIT  = 12,
   parameter int PROT_PGM_CYC = 6,
   parameter int PROT_ERS_CYC = 40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [1:0]             cmd_op,
   input  logic [ADDR_W-1:0]      cmd_addr,
   input  logic [7:0]             cmd_wdata,
   input  logic [(1<<SECT_W)-1:0] cmd_sect_sel,
   input  logic [(1<<SECT_W)-1:0] sect_prot,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [7:0]             rd_data,
   output logic                   busy
);
   localparam int DATA_W = 8;

   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("SECT_W must be at least 1 and below ADDR_W");
   end
   if (PGM_PULSES < 1 || PGM_PULSES >= PULSE_LIMIT) begin : g_bad_pulse
      $error("PGM_PULSES must be at least 1 and below PULSE_LIMIT");
   end
   if (PROT_PGM_CYC < 1 || PROT_ERS_CYC < 1) begin : g_bad_prot
      $error("protected-target durations must be at least one cycle");
   end

   logic              op_failed;
   logic              in_pgm;
   logic              accept;
   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr;
   logic [DATA_W-1:0] arr_wdata;
   logic [ADDR_W-1:0] tgt_addr;
   logic [DATA_W-1:0] arr_tgt_q;
   logic [DATA_W-1:0] arr_rd_q;

   fsg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (arr_we),
      .waddr   (arr_waddr),
      .wdata   (arr_wdata),
      .ra_addr (rd_addr),
      .ra_data (arr_rd_q),
      .rb_addr (tgt_addr),
      .rb_data (arr_tgt_q)
   );

   fsg_sequencer #(
      .ADDR_W       (ADDR_W),
      .SECT_W       (SECT_W),
      .DATA_W       (DATA_W),
      .PGM_PULSES   (PGM_PULSES),
      .PULSE_LIMIT  (PULSE_LIMIT),
      .PROT_PGM_CYC (PROT_PGM_CYC),
      .PROT_ERS_CYC (PROT_ERS_CYC)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_addr     (cmd_addr),
      .cmd_wdata    (cmd_wdata),
      .cmd_sect_sel (cmd_sect_sel),
      .sect_prot    (sect_prot),
      .tgt_q        (arr_tgt_q),
      .tgt_addr     (tgt_addr),
      .busy         (busy),
      .failed       (op_failed),
      .in_pgm       (in_pgm),
      .accept       (accept),
      .we           (arr_we),
      .waddr        (arr_waddr),
      .wdata        (arr_wdata)
   );

   fsg_status #(.DATA_W(DATA_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .busy    (busy),
      .failed  (op_failed),
      .rd_en   (rd_en),
      .arr_q   (arr_rd_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [1:0] cmd_op,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       busy,
   input logic       op_failed,
   input logic       in_pgm,
   input logic       arr_we,
   input logic [7:0] arr_wdata,
   input logic [7:0] arr_tgt_q
);
   // R3: consecutive status reads alternate bit 6
   assert_status_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

   // R8: failure only follows an active program
   assert_fail_from_pgm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_failed) |-> $past(in_pgm));

   // R9: failure holds until a reset command
   assert_fail_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_failed && !(cmd_valid && cmd_op == 2'b11)) |=> op_failed);

   // R4: a program write never raises a stored 0 bit
   assert_no_raised_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && in_pgm) |-> ((arr_wdata & ~arr_tgt_q) == 8'h00));

   // R10: storage changes only during an operation
   assert_write_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R8: no failure flag before the limit is reached
   assert_fail_bit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && !op_failed) |=> !rd_data[5]);
endmodule

bind flash_status_gen fsg_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .busy      (busy),
   .op_failed (op_failed),
   .in_pgm    (in_pgm),
   .arr_we    (arr_we),
   .arr_wdata (arr_wdata),
   .arr_tgt_q (arr_tgt_q)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
   localparam int ADDR_W = 8;
   localparam int SECT_W = 2;
   localparam int PGM_P  = 4;
   localparam int LIMIT  = 12;
   localparam int PPGM   = 6;
   localparam int PERS   = 40;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = 2'b00;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [7:0]        cmd_wdata = '0;
   logic [3:0]        cmd_sect_sel = '0;
   logic [3:0]        sect_prot = 4'b0100;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;
   logic              busy;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   flash_status_gen #(
      .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PGM_PULSES(PGM_P),
      .PULSE_LIMIT(LIMIT), .PROT_PGM_CYC(PPGM), .PROT_ERS_CYC(PERS)
   ) u_flash_status_gen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_sect_sel(cmd_sect_sel),
      .sect_prot(sect_prot), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int    m_mem [DEPTH];
   int    m_st;        // 0 idle, 1 running, 2 failed
   int    m_cnt;
   int    m_kind;      // 0 no-op burst, 1 good program, 2 doomed program, 3 erase
   int    m_addr, m_data, m_mask;
   bit    m_tog;
   int    exp_rd;
   string exp_tag = "R2";

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = 8'hFF;
         m_st = 0; m_cnt = 0; m_tog = 0; exp_rd = 0; exp_tag = "R1";
      end else begin
         int pre;
         pre = m_st;
         if (rd_en) begin
            if (pre != 0) begin
               m_tog  = !m_tog;
               exp_rd = (int'(m_tog) << 6) | ((pre == 2) ? 32 : 0);
               exp_tag = "R3";
            end else begin
               exp_rd  = m_mem[rd_addr];
               exp_tag = "R2";
            end
         end
         if (pre == 1) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_st = 0;
               if (m_kind == 1) m_mem[m_addr] = m_mem[m_addr] & m_data;
               else if (m_kind == 2) m_st = 2;
               else if (m_kind == 3)
                  for (int a = 0; a < DEPTH; a++)
                     if (m_mask[a >> (ADDR_W - SECT_W)]) m_mem[a] = 8'hFF;
            end
         end else if (pre == 2) begin
            if (cmd_valid && cmd_op == 2'b11) m_st = 0;
         end else if (cmd_valid && cmd_op == 2'b01) begin
            m_st = 1; m_tog = 0;
            m_addr = cmd_addr; m_data = cmd_wdata;
            if (sect_prot[cmd_addr >> (ADDR_W - SECT_W)]) begin
               m_kind = 0; m_cnt = PPGM;
            end else if ((cmd_wdata & ~m_mem[cmd_addr] & 8'hFF) != 0) begin
               m_kind = 2; m_cnt = LIMIT;
            end else begin
               m_kind = 1; m_cnt = PGM_P;
            end
         end else if (cmd_valid && cmd_op == 2'b10 && cmd_sect_sel != 0) begin
            m_st = 1; m_tog = 0;
            m_mask = cmd_sect_sel & ~sect_prot;
            if (m_mask == 0) begin m_kind = 0; m_cnt = PERS; end
            else begin m_kind = 3; m_cnt = DEPTH; end
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk({exp_tag, " rd_data vs model"}, rd_data, exp_rd);
         chk("R10 busy vs model", busy, (m_st != 0));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic issue(input logic [1:0] op, input int addr, input int data, input int sel);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr[ADDR_W-1:0];
      cmd_wdata = data[7:0]; cmd_sect_sel = sel[3:0];
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd(input int addr, output int val);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = addr[ADDR_W-1:0];
      @(negedge clk);
      rd_en = 1'b0;
      val = rd_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n, v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 busy after reset", busy, 0);
      chk("R1 rd_data after reset", rd_data, 0);
      rd(8'h10, v); chk("R1 erased byte", v, 8'hFF);

      // R4 program from erased, then narrowing
      issue(2'b01, 8'h10, 8'hA5, 0);
      wait_idle(n); chk("R4 program duration", n, PGM_P);
      rd(8'h10, v); chk("R4 programmed value", v, 8'hA5);
      issue(2'b01, 8'h10, 8'h21, 0);
      wait_idle(n);
      rd(8'h10, v); chk("R4 AND store", v, 8'h21);

      // R3 back-to-back status reads
      issue(2'b01, 8'h11, 8'h0F, 0);
      rd_en = 1'b1; rd_addr = 8'h11;
      @(negedge clk); chk("R3 first status byte", rd_data, 8'h40);
      @(negedge clk); chk("R3 second status byte", rd_data, 8'h00);
      rd_en = 1'b0;
      wait_idle(n);
      rd(8'h11, v); chk("R2 read after status", v, 8'h0F);

      // place data in sector 2 while unprotected, then protect it again
      sect_prot = 4'b0000;
      issue(2'b01, 8'h85, 8'h3C, 0); wait_idle(n);
      issue(2'b01, 8'h40, 8'h77, 0); wait_idle(n);
      sect_prot = 4'b0100;

      // R5 protected program
      issue(2'b01, 8'h85, 8'h00, 0);
      wait_idle(n); chk("R5 protected program duration", n, PPGM);
      rd(8'h85, v); chk("R5 protected data kept", v, 8'h3C);

      // R6 erase selecting only protected sectors
      issue(2'b10, 0, 0, 4'b0100);
      wait_idle(n); chk("R6 protected erase duration", n, PERS);
      rd(8'h85, v); chk("R6 protected data kept", v, 8'h3C);

      // R7 mixed erase: sectors 0 and 2 selected, 2 protected
      issue(2'b10, 0, 0, 4'b0101);
      wait_idle(n); chk("R7 erase duration", n, DEPTH);
      rd(8'h10, v); chk("R7 erased byte", v, 8'hFF);
      rd(8'h11, v); chk("R7 erased byte 2", v, 8'hFF);
      rd(8'h85, v); chk("R7 protected sector skipped", v, 8'h3C);
      rd(8'h40, v); chk("R7 unselected sector kept", v, 8'h77);

      // R11 empty erase
      issue(2'b10, 0, 0, 0);
      chk("R11 empty erase ignored", busy, 0);

      // R8 doomed program: 77 -> FF needs raised bits
      issue(2'b01, 8'h40, 8'hFF, 0);
      rd_en = 1'b1; rd_addr = 8'h40;
      for (int k = 1; k <= LIMIT + 1; k++) begin
         @(negedge clk);
         chk("R8 fail bit timing", rd_data[5], (k == LIMIT + 1));
      end
      rd_en = 1'b0;
      chk("R8 busy after failure", busy, 1);
      // R10 requests ignored while failed
      issue(2'b01, 8'h50, 8'h00, 0);
      issue(2'b10, 0, 0, 4'b0010);
      chk("R10 still failed", busy, 1);
      // R9 reset command leaves failure
      issue(2'b11, 0, 0, 0);
      chk("R9 reset clears busy", busy, 0);
      rd(8'h40, v); chk("R8 target unchanged", v, 8'h77);
      rd(8'h50, v); chk("R10 ignored program", v, 8'hFF);

      // R9 reset while idle has no effect
      issue(2'b11, 0, 0, 0);
      chk("R9 idle reset", busy, 0);
      rd(8'h40, v); chk("R9 idle reset keeps data", v, 8'h77);

      // R10 request during a running program
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 8'h41; cmd_wdata = 8'h00;
      @(negedge clk);
      cmd_addr = 8'h42;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      wait_idle(n);
      rd(8'h41, v); chk("R4 first program done", v, 8'h00);
      rd(8'h42, v); chk("R10 overlapping program ignored", v, 8'hFF);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule